// File: doc/BRIEF.md
# Last-Level Cache Line Coherence Controller

This block tracks the coherence state of every line in a small last-level cache and answers requests from the caches below it. Each line is in one of five stable states (modified, owned, exclusive, shared, invalid). Read requests that hit are answered with data, and the read may demote the line or invalidate it. Requests the cache cannot satisfy are passed to the directory unchanged. Dirty and clean victims from a lower cache are installed in two phases. The block acknowledges the victim at once. It then holds the line in a waiting condition until the data message arrives. The shared flag on that message selects the final state.

Each waiting line records its prior stable state, the target class of the victim and the identity of the requestor. A cancel from that same requestor drops the pending install and leaves the prior state in force. Any request that meets a waiting line is parked in a single retry slot. While the slot is occupied, the request port is closed. The parked request is presented again as soon as its line is stable. Responses leave after a long fixed latency and directory requests after a short one, both set by parameters. Tags and data are held in a register file with one entry per line index.

Top module: `llc_line_ctrl`

## Requirements
- R1: After reset every line is invalid, `req_ready_o` is 1, and `rsp_valid_o`, `dir_valid_o` and `err_o` are 0.
- R2: A plain read (op 0) that hits returns a response of kind 0 with the line data. `rsp_dirty_o` is 1 when the line was modified or owned. Modified becomes owned, exclusive becomes shared, and owned and shared are unchanged.
- R3: A shared read (op 1) that hits returns kind 0 with data. Modified or owned ends owned, and exclusive or shared ends shared.
- R4: A modify read (op 2) that hits a modified or exclusive line returns kind 1 with data and `rsp_dirty_o` set for modified only. The line becomes invalid.
- R5: A modify read, or a change-to-dirty request (op 3), on an owned or shared line goes to the directory with its op code unchanged and no response. Any read on an invalid line is forwarded the same way.
- R6: A victim (op 4 dirty, 5 dirty-shared, 6 clean, 7 clean-shared) on a stable line returns kind 2 (acknowledge) to the requestor, with `rsp_dirty_o` 0. The line then waits for data.
- R7: Data landing on a waiting line sets its final state and stores the data. After op 4 the line is owned if `dat_shared_i` is set and modified otherwise. After op 6 it is shared if the flag is set and exclusive otherwise. After op 5 it is always owned, and after op 7 always shared.
- R8: A cancel (op 8) from the requestor recorded for a waiting line ends the wait with the prior stable state intact. It produces no response and no directory request.
- R9: A request for a waiting line, including a cancel from another requestor, is held in the retry slot with `req_ready_o` at 0. It is re-presented once the line is stable.
- R10: A response appears exactly `RSP_LAT` cycles after the cycle in which its request was accepted, and a directory request exactly `DIR_LAT` cycles after.
- R11: `err_o[0]` pulses for an undefined request: change-to-dirty on a modified or exclusive line, a cancel on a stable line, or op codes 9 to 15. `err_o[1]` pulses for data on a line that is not waiting. Either pulse appears in the cycle after the event, the line is left unchanged, and at most one bit is set at a time.
- R12: A read held in the retry slot returns the data that landed while it waited, addressed to its own requestor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when high |
| req_op_i | input | 4 | Request op code |
| req_line_i | input | LINE_W | Line index |
| req_id_i | input | ID_W | Requestor identity |
| dat_valid_i | input | 1 | Victim data message present |
| dat_line_i | input | LINE_W | Line index of the data |
| dat_shared_i | input | 1 | Shared flag of the data message |
| dat_data_i | input | DATA_W | Line data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_kind_o | output | 2 | 0 shared data, 1 modified data, 2 acknowledge |
| rsp_dirty_o | output | 1 | Data differs from memory |
| rsp_id_o | output | ID_W | Destination requestor |
| rsp_line_o | output | LINE_W | Line index |
| rsp_data_o | output | DATA_W | Line data |
| dir_valid_o | output | 1 | Directory request valid |
| dir_op_o | output | 4 | Forwarded op code |
| dir_id_o | output | ID_W | Original requestor |
| dir_line_o | output | LINE_W | Line index |
| err_o | output | 2 | Undefined request / stray data pulse |

## Verification
A corrupted stable state is visible at the ports only through the next read of that line. The response kind, the dirty bit, or a forward in place of data shows it `RSP_LAT` or `DIR_LAT` cycles later. For that reason, each install is followed by a modify read and a plain read. A lost waiting flag shows one cycle after the data lands, as a stray-data error pulse. A stuck waiting flag shows as `req_ready_o` staying low after a read of that line. A wrong recorded requestor shows when a cancel either fails to restore the prior state or triggers an error pulse after the data lands.

// File: rtl/llc_pkg.sv
`timescale 1ns/1ps
package llc_pkg;
  typedef enum logic [2:0] {ST_I, ST_S, ST_E, ST_O, ST_M} line_st_e;

  typedef enum logic [3:0] {
    OP_RD       = 4'd0,
    OP_RD_SH    = 4'd1,
    OP_RD_MOD   = 4'd2,
    OP_CTOD     = 4'd3,
    OP_VIC_D    = 4'd4,
    OP_VIC_D_SH = 4'd5,
    OP_VIC_C    = 4'd6,
    OP_VIC_C_SH = 4'd7,
    OP_CANCEL   = 4'd8
  } req_op_e;

  typedef enum logic [1:0] {
    RSP_DATA_SH  = 2'd0,
    RSP_DATA_MOD = 2'd1,
    RSP_WB_ACK   = 2'd2
  } rsp_kind_e;

  typedef enum logic [1:0] {TGT_M, TGT_O, TGT_E, TGT_S} vic_tgt_e;

  // final state once victim data lands
  function automatic line_st_e land_state(vic_tgt_e tgt, logic shared);
    case (tgt)
      TGT_M:   return shared ? ST_O : ST_M;
      TGT_E:   return shared ? ST_S : ST_E;
      TGT_O:   return ST_O;
      default: return ST_S;
    endcase
  endfunction
endpackage

// File: rtl/llc_delay_line.sv
`timescale 1ns/1ps
module llc_delay_line #(
  parameter int W   = 8,
  parameter int LAT = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o
);
  logic [LAT-1:0] v_q;
  logic [W-1:0]   d_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q[0] <= 1'b0;
      d_q[0] <= '0;
    end else begin
      v_q[0] <= in_valid_i;
      d_q[0] <= in_data_i;
    end
  end

  for (genvar g = 1; g < LAT; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[g] <= 1'b0;
        d_q[g] <= '0;
      end else begin
        v_q[g] <= v_q[g-1];
        d_q[g] <= d_q[g-1];
      end
    end
  end

  assign out_valid_o = v_q[LAT-1];
  assign out_data_o  = d_q[LAT-1];
endmodule

// File: rtl/llc_req_decode.sv
`timescale 1ns/1ps
module llc_req_decode
  import llc_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  line_st_e        st_i,
  input  logic            busy_i,
  input  logic [ID_W-1:0] own_i,
  input  logic [3:0]      op_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            landing_i,
  output logic            retry_o,
  output logic            err_o,
  output logic            rsp_o,
  output rsp_kind_e       rsp_kind_o,
  output logic            rsp_dirty_o,
  output logic            dir_o,
  output logic            upd_o,
  output line_st_e        nxt_st_o,
  output logic            nxt_busy_o,
  output vic_tgt_e        nxt_tgt_o,
  output logic [ID_W-1:0] nxt_own_o
);
  logic dirty;
  assign dirty = (st_i == ST_M) || (st_i == ST_O);

  always_comb begin
    retry_o     = 1'b0;
    err_o       = 1'b0;
    rsp_o       = 1'b0;
    rsp_kind_o  = RSP_DATA_SH;
    rsp_dirty_o = 1'b0;
    dir_o       = 1'b0;
    upd_o       = 1'b0;
    nxt_st_o    = st_i;
    nxt_busy_o  = busy_i;
    nxt_tgt_o   = TGT_M;
    nxt_own_o   = own_i;
    if (busy_i || landing_i) begin
      if (op_i == OP_CANCEL && busy_i && !landing_i && id_i == own_i) begin
        upd_o      = 1'b1;
        nxt_busy_o = 1'b0;
      end else begin
        retry_o = 1'b1;
      end
    end else begin
      case (op_i)
        OP_RD: begin
          if (st_i == ST_I) dir_o = 1'b1;
          else begin
            rsp_o       = 1'b1;
            rsp_dirty_o = dirty;
            upd_o       = 1'b1;
            if (st_i == ST_M) nxt_st_o = ST_O;
            else if (st_i == ST_E) nxt_st_o = ST_S;
          end
        end
        OP_RD_SH: begin
          if (st_i == ST_I) dir_o = 1'b1;
          else begin
            rsp_o       = 1'b1;
            rsp_dirty_o = dirty;
            upd_o       = 1'b1;
            nxt_st_o    = dirty ? ST_O : ST_S;
          end
        end
        OP_RD_MOD: begin
          if (st_i == ST_M || st_i == ST_E) begin
            rsp_o       = 1'b1;
            rsp_kind_o  = RSP_DATA_MOD;
            rsp_dirty_o = (st_i == ST_M);
            upd_o       = 1'b1;
            nxt_st_o    = ST_I;
          end else dir_o = 1'b1;
        end
        OP_CTOD: begin
          if (st_i == ST_M || st_i == ST_E) err_o = 1'b1;
          else dir_o = 1'b1;
        end
        OP_VIC_D, OP_VIC_D_SH, OP_VIC_C, OP_VIC_C_SH: begin
          rsp_o      = 1'b1;
          rsp_kind_o = RSP_WB_ACK;
          upd_o      = 1'b1;
          nxt_busy_o = 1'b1;
          nxt_own_o  = id_i;
          case (op_i)
            OP_VIC_D:    nxt_tgt_o = TGT_M;
            OP_VIC_D_SH: nxt_tgt_o = TGT_O;
            OP_VIC_C:    nxt_tgt_o = TGT_E;
            default:     nxt_tgt_o = TGT_S;
          endcase
        end
        default: err_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/llc_line_ctrl.sv
`timescale 1ns/1ps
module llc_line_ctrl
  import llc_pkg::*;
#(
  parameter int LINES   = 8,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4,
  parameter int RSP_LAT = 35,
  parameter int DIR_LAT = 1,
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [3:0]        req_op_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic              dat_valid_i,
  input  logic [LINE_W-1:0] dat_line_i,
  input  logic              dat_shared_i,
  input  logic [DATA_W-1:0] dat_data_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_kind_o,
  output logic              rsp_dirty_o,
  output logic [ID_W-1:0]   rsp_id_o,
  output logic [LINE_W-1:0] rsp_line_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              dir_valid_o,
  output logic [3:0]        dir_op_o,
  output logic [ID_W-1:0]   dir_id_o,
  output logic [LINE_W-1:0] dir_line_o,
  output logic [1:0]        err_o
);
  localparam int RSP_W = 2 + 1 + ID_W + LINE_W + DATA_W;
  localparam int DIR_W = 4 + ID_W + LINE_W;

  line_st_e          st_q   [LINES];
  vic_tgt_e          tgt_q  [LINES];
  logic [ID_W-1:0]   own_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic [LINES-1:0]  busy_q;

  logic              rt_valid_q;
  logic [3:0]        rt_op_q;
  logic [LINE_W-1:0] rt_line_q;
  logic [ID_W-1:0]   rt_id_q;
  logic [1:0]        err_q;

  logic              rt_go, new_go, cur_valid, landing;
  logic [3:0]        cur_op;
  logic [LINE_W-1:0] cur_line;
  logic [ID_W-1:0]   cur_id;

  logic      dec_retry, dec_err, dec_rsp, dec_dirty, dec_dir, dec_upd;
  logic      nxt_busy;
  rsp_kind_e dec_kind;
  line_st_e  nxt_st;
  vic_tgt_e  nxt_tgt;
  logic [ID_W-1:0] nxt_own;
  logic      rsp_push, dir_push, stray_dat;

  // parked request goes first once its line is stable and not landing
  assign rt_go     = rt_valid_q && !busy_q[rt_line_q] &&
                     !(dat_valid_i && dat_line_i == rt_line_q);
  assign new_go    = req_valid_i && !rt_valid_q;
  assign cur_valid = rt_go || new_go;
  assign cur_op    = rt_go ? rt_op_q   : req_op_i;
  assign cur_line  = rt_go ? rt_line_q : req_line_i;
  assign cur_id    = rt_go ? rt_id_q   : req_id_i;
  assign landing   = dat_valid_i && dat_line_i == cur_line;
  assign req_ready_o = !rt_valid_q;

  llc_req_decode #(.ID_W(ID_W)) u_dec (
    .st_i       (st_q[cur_line]),
    .busy_i     (busy_q[cur_line]),
    .own_i      (own_q[cur_line]),
    .op_i       (cur_op),
    .id_i       (cur_id),
    .landing_i  (landing),
    .retry_o    (dec_retry),
    .err_o      (dec_err),
    .rsp_o      (dec_rsp),
    .rsp_kind_o (dec_kind),
    .rsp_dirty_o(dec_dirty),
    .dir_o      (dec_dir),
    .upd_o      (dec_upd),
    .nxt_st_o   (nxt_st),
    .nxt_busy_o (nxt_busy),
    .nxt_tgt_o  (nxt_tgt),
    .nxt_own_o  (nxt_own)
  );

  assign rsp_push  = cur_valid && dec_rsp;
  assign dir_push  = cur_valid && dec_dir;
  assign stray_dat = dat_valid_i && !busy_q[dat_line_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= ST_I;
        tgt_q[i]  <= TGT_M;
        own_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (dat_valid_i && dat_line_i == LINE_W'(i) && busy_q[i]) begin
          st_q[i]   <= land_state(tgt_q[i], dat_shared_i);
          busy_q[i] <= 1'b0;
          data_q[i] <= dat_data_i;
        end else if (cur_valid && dec_upd && cur_line == LINE_W'(i)) begin
          st_q[i]   <= nxt_st;
          busy_q[i] <= nxt_busy;
          if (nxt_busy && !busy_q[i]) begin
            tgt_q[i] <= nxt_tgt;
            own_q[i] <= nxt_own;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rt_valid_q <= 1'b0;
      rt_op_q    <= '0;
      rt_line_q  <= '0;
      rt_id_q    <= '0;
      err_q      <= '0;
    end else begin
      if (rt_go) rt_valid_q <= 1'b0;
      if (cur_valid && dec_retry) begin
        rt_valid_q <= 1'b1;
        rt_op_q    <= cur_op;
        rt_line_q  <= cur_line;
        rt_id_q    <= cur_id;
      end
      err_q[0] <= cur_valid && dec_err;
      err_q[1] <= stray_dat && !(cur_valid && dec_err);
    end
  end

  assign err_o = err_q;

  logic [RSP_W-1:0] rsp_in, rsp_out;
  logic [DIR_W-1:0] dir_in, dir_out;
  assign rsp_in = {dec_kind, dec_dirty, cur_id, cur_line,
                   (dec_kind == RSP_WB_ACK) ? '0 : data_q[cur_line]};
  assign dir_in = {cur_op, cur_id, cur_line};

  llc_delay_line #(.W(RSP_W), .LAT(RSP_LAT)) u_rsp_dly (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (rsp_push),
    .in_data_i  (rsp_in),
    .out_valid_o(rsp_valid_o),
    .out_data_o (rsp_out)
  );

  llc_delay_line #(.W(DIR_W), .LAT(DIR_LAT)) u_dir_dly (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (dir_push),
    .in_data_i  (dir_in),
    .out_valid_o(dir_valid_o),
    .out_data_o (dir_out)
  );

  assign {rsp_kind_o, rsp_dirty_o, rsp_id_o, rsp_line_o, rsp_data_o} = rsp_out;
  assign {dir_op_o, dir_id_o, dir_line_o} = dir_out;
endmodule

// File: rtl/llc_line_ctrl_chk.sv
`timescale 1ns/1ps
module llc_line_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       rsp_valid_o,
  input logic [1:0] rsp_kind_o,
  input logic       rsp_dirty_o,
  input logic [1:0] err_o,
  input logic       cur_valid_i,
  input logic [3:0] cur_op_i,
  input logic       rsp_push_i,
  input logic       dir_push_i
);
  p_err_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(err_o));

  p_ack_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_kind_o == 2'd2 |-> !rsp_dirty_o);

  p_kind_legal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_kind_o != 2'd3);

  p_cancel_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_valid_i && cur_op_i == 4'd8 |-> !rsp_push_i && !dir_push_i);

  p_ctod_no_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_valid_i && cur_op_i == 4'd3 |-> !rsp_push_i);

  p_ready_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_ready_o) |-> $past(req_valid_i));

  p_single_action_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_push_i && dir_push_i));
endmodule

bind llc_line_ctrl llc_line_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .rsp_kind_o (rsp_kind_o),
  .rsp_dirty_o(rsp_dirty_o),
  .err_o      (err_o),
  .cur_valid_i(cur_valid),
  .cur_op_i   (cur_op),
  .rsp_push_i (rsp_push),
  .dir_push_i (dir_push)
);

// File: tb/llc_line_ctrl_tb.sv
`timescale 1ns/1ps
module llc_line_ctrl_tb;
  localparam int RSP_LAT = 35;
  localparam int DIR_LAT = 1;
  localparam int LW      = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic req_valid_i = 1'b0, req_ready_o;
  logic [3:0] req_op_i = '0;
  logic [LW-1:0] req_line_i = '0;
  logic [3:0] req_id_i = '0;
  logic dat_valid_i = 1'b0, dat_shared_i = 1'b0;
  logic [LW-1:0] dat_line_i = '0;
  logic [31:0] dat_data_i = '0;
  logic rsp_valid_o, rsp_dirty_o, dir_valid_o;
  logic [1:0] rsp_kind_o, err_o;
  logic [3:0] rsp_id_o, dir_op_o, dir_id_o;
  logic [LW-1:0] rsp_line_o, dir_line_o;
  logic [31:0] rsp_data_o;

  llc_line_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_op_i(req_op_i),
    .req_line_i(req_line_i), .req_id_i(req_id_i),
    .dat_valid_i(dat_valid_i), .dat_line_i(dat_line_i), .dat_shared_i(dat_shared_i),
    .dat_data_i(dat_data_i),
    .rsp_valid_o(rsp_valid_o), .rsp_kind_o(rsp_kind_o), .rsp_dirty_o(rsp_dirty_o),
    .rsp_id_o(rsp_id_o), .rsp_line_o(rsp_line_o), .rsp_data_o(rsp_data_o),
    .dir_valid_o(dir_valid_o), .dir_op_o(dir_op_o), .dir_id_o(dir_id_o),
    .dir_line_o(dir_line_o), .err_o(err_o)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, acc = 0;
  int rsp_cnt = 0, dir_cnt = 0, e0_cnt = 0, e1_cnt = 0, both_cnt = 0;
  int rsp_cyc = 0, dir_cyc = 0;
  int rsp0 = 0, dir0 = 0;
  logic [1:0] r_kind; logic r_dirty; logic [3:0] r_id; logic [31:0] r_data;
  logic [3:0] d_op; logic [LW-1:0] d_line;
  bit done = 0;

  always_ff @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rsp_valid_o) begin
      rsp_cnt++; rsp_cyc = cyc;
      r_kind = rsp_kind_o; r_dirty = rsp_dirty_o; r_id = rsp_id_o; r_data = rsp_data_o;
    end
    if (dir_valid_o) begin
      dir_cnt++; dir_cyc = cyc; d_op = dir_op_o; d_line = dir_line_o;
    end
    if (err_o[0]) e0_cnt++;
    if (err_o[1]) e1_cnt++;
    if (err_o == 2'b11) both_cnt++;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk); #1;
  endtask

  task automatic send(input logic [3:0] op, input int line, input int id);
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1'b1; req_op_i = op; req_line_i = line[LW-1:0]; req_id_i = id[3:0];
    @(posedge clk); @(negedge clk);
    acc = cyc - 1;
    req_valid_i = 1'b0;
  endtask

  task automatic land(input int line, input bit sh, input logic [31:0] d);
    @(negedge clk);
    dat_valid_i = 1'b1; dat_line_i = line[LW-1:0]; dat_shared_i = sh; dat_data_i = d;
    @(negedge clk);
    dat_valid_i = 1'b0;
  endtask

  task automatic do_req(input logic [3:0] op, input int line, input int id);
    rsp0 = rsp_cnt; dir0 = dir_cnt;
    send(op, line, id);
    idle(RSP_LAT + 2);
  endtask

  task automatic exp_rsp(input string req, input int kind, input bit dirty, input logic [31:0] d);
    chk(req, "rsp count", rsp_cnt, rsp0 + 1);
    chk(req, "dir count", dir_cnt, dir0);
    chk(req, "rsp kind", r_kind, kind);
    chk(req, "rsp dirty", r_dirty, dirty);
    if (kind != 2) chk(req, "rsp data", r_data, d);
  endtask

  task automatic exp_dir(input string req, input int op, input int line);
    chk(req, "dir count", dir_cnt, dir0 + 1);
    chk(req, "rsp count", rsp_cnt, rsp0);
    chk(req, "dir op", d_op, op);
    chk(req, "dir line", d_line, line);
    chk(req, "dir latency", dir_cyc - acc, DIR_LAT);
  endtask

  task automatic install(input logic [3:0] op, input int line, input bit sh, input logic [31:0] d);
    do_req(op, line, 1);
    exp_rsp("R6", 2, 1'b0, 0);
    land(line, sh, d);
    idle(2);
  endtask

  task automatic t_reset;
    chk("R1", "ready", req_ready_o, 1);
    chk("R1", "rsp valid", rsp_valid_o, 0);
    chk("R1", "dir valid", dir_valid_o, 0);
    chk("R1", "err", err_o, 0);
    do_req(4'd0, 0, 2);
    exp_dir("R1", 0, 0);
  endtask

  task automatic t_modify_read;
    do_req(4'd4, 1, 3);
    exp_rsp("R6", 2, 1'b0, 0);
    chk("R6", "ack id", r_id, 3);
    chk("R10", "rsp latency", rsp_cyc - acc, RSP_LAT);
    land(1, 1'b0, 32'hA5A5_0001);
    idle(2);
    do_req(4'd2, 1, 4);
    exp_rsp("R4", 1, 1'b1, 32'hA5A5_0001);
    chk("R4", "rsp id", r_id, 4);
    do_req(4'd0, 1, 4);
    exp_dir("R4", 0, 1);
  endtask

  task automatic t_plain_read;
    install(4'd4, 2, 1'b0, 32'h0000_0022);
    do_req(4'd0, 2, 2);
    exp_rsp("R2", 0, 1'b1, 32'h0000_0022);
    do_req(4'd0, 2, 2);
    exp_rsp("R2", 0, 1'b1, 32'h0000_0022);
    do_req(4'd2, 2, 2);
    exp_dir("R2", 2, 2);
    install(4'd6, 3, 1'b0, 32'h0000_0033);
    do_req(4'd0, 3, 2);
    exp_rsp("R2", 0, 1'b0, 32'h0000_0033);
    do_req(4'd2, 3, 2);
    exp_dir("R2", 2, 3);
    do_req(4'd3, 3, 2);
    exp_dir("R5", 3, 3);
  endtask

  task automatic t_shared_read;
    install(4'd6, 4, 1'b0, 32'h0000_0044);
    do_req(4'd1, 4, 5);
    exp_rsp("R3", 0, 1'b0, 32'h0000_0044);
    do_req(4'd2, 4, 5);
    exp_dir("R3", 2, 4);
    install(4'd4, 5, 1'b0, 32'h0000_0055);
    do_req(4'd1, 5, 5);
    exp_rsp("R3", 0, 1'b1, 32'h0000_0055);
    do_req(4'd0, 5, 5);
    exp_rsp("R3", 0, 1'b1, 32'h0000_0055);
    do_req(4'd2, 5, 5);
    exp_dir("R3", 2, 5);
  endtask

  task automatic t_landing;
    // dirty + shared flag -> owned
    install(4'd4, 6, 1'b1, 32'h0000_0061);
    do_req(4'd0, 6, 1); exp_rsp("R7", 0, 1'b1, 32'h0000_0061);
    do_req(4'd2, 6, 1); exp_dir("R7", 2, 6);
    // clean + shared flag -> shared (hit victim on owned line)
    install(4'd6, 6, 1'b1, 32'h0000_0062);
    do_req(4'd0, 6, 1); exp_rsp("R7", 0, 1'b0, 32'h0000_0062);
    do_req(4'd2, 6, 1); exp_dir("R7", 2, 6);
    // dirty-shared, flag clear -> owned
    install(4'd5, 6, 1'b0, 32'h0000_0063);
    do_req(4'd0, 6, 1); exp_rsp("R7", 0, 1'b1, 32'h0000_0063);
    do_req(4'd2, 6, 1); exp_dir("R7", 2, 6);
    // clean-shared, flag clear -> shared
    install(4'd7, 6, 1'b0, 32'h0000_0064);
    do_req(4'd0, 6, 1); exp_rsp("R7", 0, 1'b0, 32'h0000_0064);
    do_req(4'd2, 6, 1); exp_dir("R7", 2, 6);
  endtask

  task automatic t_cancel;
    int e0;
    install(4'd6, 6, 1'b0, 32'h0000_0065);   // exclusive
    do_req(4'd4, 6, 5);
    exp_rsp("R8", 2, 1'b0, 0);
    do_req(4'd8, 6, 5);
    chk("R8", "cancel rsp count", rsp_cnt, rsp0);
    chk("R8", "cancel dir count", dir_cnt, dir0);
    chk("R8", "ready after cancel", req_ready_o, 1);
    do_req(4'd2, 6, 5);
    exp_rsp("R8", 1, 1'b0, 32'h0000_0065);
    // foreign cancel is parked until data lands
    do_req(4'd4, 6, 5);
    exp_rsp("R6", 2, 1'b0, 0);
    e0 = e0_cnt;
    send(4'd8, 6, 9);
    idle(1);
    chk("R9", "ready low on parked cancel", req_ready_o, 0);
    chk("R9", "parked cancel no err", e0_cnt, e0);
    land(6, 1'b0, 32'h0000_0066);
    idle(3);
    chk("R9", "ready restored", req_ready_o, 1);
    chk("R11", "stale cancel err0", e0_cnt, e0 + 1);
    do_req(4'd2, 6, 5);
    exp_rsp("R9", 1, 1'b1, 32'h0000_0066);
  endtask

  task automatic t_retry;
    int n0;
    n0 = rsp_cnt;
    send(4'd4, 7, 1);
    send(4'd0, 7, 2);
    idle(1);
    chk("R9", "ready low", req_ready_o, 0);
    idle(RSP_LAT + 2);
    chk("R9", "only ack while parked", rsp_cnt, n0 + 1);
    chk("R9", "still parked", req_ready_o, 0);
    land(7, 1'b1, 32'h0000_0077);
    idle(RSP_LAT + 3);
    chk("R12", "rsp count", rsp_cnt, n0 + 2);
    chk("R12", "rsp kind", r_kind, 0);
    chk("R12", "rsp data", r_data, 32'h0000_0077);
    chk("R12", "rsp id", r_id, 2);
    chk("R12", "rsp dirty", r_dirty, 1);
    chk("R9", "ready back", req_ready_o, 1);
  endtask

  task automatic t_errors;
    int e0, e1;
    install(4'd4, 0, 1'b0, 32'h0000_0010);    // modified
    e0 = e0_cnt; e1 = e1_cnt;
    do_req(4'd3, 0, 3);
    chk("R11", "ctod err0", e0_cnt, e0 + 1);
    chk("R11", "ctod no rsp", rsp_cnt, rsp0);
    chk("R11", "ctod no dir", dir_cnt, dir0);
    land(0, 1'b1, 32'hDEAD_BEEF);
    idle(2);
    chk("R11", "stray data err1", e1_cnt, e1 + 1);
    do_req(4'd12, 0, 3);
    chk("R11", "bad op err0", e0_cnt, e0 + 2);
    chk("R11", "bad op no rsp", rsp_cnt, rsp0);
    do_req(4'd8, 0, 3);
    chk("R11", "cancel stable err0", e0_cnt, e0 + 3);
    do_req(4'd2, 0, 3);
    exp_rsp("R11", 1, 1'b1, 32'h0000_0010);
    chk("R11", "never both bits", both_cnt, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_modify_read();
    t_plain_read();
    t_shared_read();
    t_landing();
    t_cancel();
    t_retry();
    t_errors();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule